// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Independent Data and Line Inversion

This block sends and receives asynchronous character frames over one serial output and one serial input. A byte handed over on the parallel transmit port goes out as a low start bit, eight data bits, an optional parity bit and one or two high stop bits. The receiver rebuilds bytes from the input line and delivers them on a parallel read port with per-frame error flags. All bit timing comes from a single-cycle enable, `baudTick`, that pulses sixteen times per bit period.

Two inversion controls act independently of each other. Data inversion complements only the eight data bits: the transmitter complements the byte before shifting it out, and the receiver complements the assembled byte before presenting it. Parity always covers the data bits as they actually appear on the line. Line inversion complements the whole waveform on both pins: every bit of a transmitted frame and the idle level on the output, and the input before any edge detection or sampling. Two transceivers with matching settings therefore exchange bytes unchanged.

The configuration inputs are sampled live. They may only be changed while both directions are idle, that is, between frames.

Top module: `dualpol_uart`

## Requirements
- R1: A transmitted frame, seen before line inversion, is a low start bit, eight data bits, a parity bit only when `cfgParityEn`=1, then one high stop bit when `cfgTwoStop`=0 or two when it is 1. Each bit lasts 16 `baudTick` pulses, and the line is high when idle.
- R2: With `cfgMsbFirst`=0 the data bits leave and arrive least significant bit first; with `cfgMsbFirst`=1 they leave and arrive most significant bit first.
- R3: The parity bit is the XOR of the eight data bits as sent on the line, XORed with `cfgParityOdd`. A value of 0 selects even parity and 1 selects odd parity.
- R4: With `cfgDataInv`=1 the transmitted data bits are the complement of `txData`, and `rxData` is the complement of the received data bits. Start, parity and stop bits are unaffected.
- R5: With `cfgLineInv`=1 the `txd` level is the complement of the R1 waveform for every bit of the frame and while idle.
- R6: With `cfgLineInv`=1 the receiver complements `rxd` before start detection and sampling, so an inverted frame is received as a normal one.
- R7: `txReady` is 1 only while the transmitter is idle. A byte is accepted on a cycle with `txValid`=1 and `txReady`=1. `txReady` then stays 0 until the last stop bit has been sent.
- R8: The receiver starts on a high-to-low change of the (corrected) line and re-checks it after 8 ticks. A line that is high again by then is ignored, and no byte is produced.
- R9: After a frame ends, `rxValid` stays 1 until a cycle with `rxRead`=1. That cycle clears `rxValid` and all three error flags. The flags are only ever 1 while `rxValid` is 1.
- R10: `rxParityErr`=1 for a delivered frame when parity is enabled and the received parity bit differs from the R3 value computed over the received data bits.
- R11: `rxFrameErr`=1 for a delivered frame when any of its stop bits is sampled low, including the second stop bit.
- R12: `rxOverrun`=1 when a frame ends while the previous byte is still unread. The newer byte then replaces the older one in `rxData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | Enable pulse at 16 times the bit rate |
| cfgMsbFirst | input | 1 | 1 = data most significant bit first |
| cfgParityEn | input | 1 | 1 = parity bit present |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even |
| cfgTwoStop | input | 1 | 1 = two stop bits, 0 = one |
| cfgDataInv | input | 1 | 1 = complement data bits on transmit and receive |
| cfgLineInv | input | 1 | 1 = complement both serial pins |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Transmitter idle, byte can be taken |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | Received byte not yet read |
| rxRead | input | 1 | Consume the received byte and flags |
| rxParityErr | output | 1 | Parity mismatch in held frame |
| rxFrameErr | output | 1 | Stop bit low in held frame |
| rxOverrun | output | 1 | Unread byte was overwritten |

## Verification
Some properties are checked on every cycle. The output sits at the selected idle level whenever the transmitter is ready, and a handshake always makes it busy. The line never moves between baud ticks. A received byte stays valid until it is read, and no error flag appears without a valid byte. The bench scenarios are what show the rest. These are the exact waveform of each frame for each bit order, parity sense, stop count and inversion pair, and the byte returned through a loop-back. They also cover frames driven straight into the receiver: inverted frames, corrupted parity, a low first or second stop bit, a short false start, and two unread frames in a row.

// File: rtl/dualpol_uart_pkg.sv
package dualpol_uart_pkg;

  // Position inside a character frame, shared by both directions
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic   txLoad;    // capture the outgoing byte and its parity
    logic   txShift;   // advance to the next data bit
    phase_e txPhase;   // which level the output shows
    logic   rxClear;   // start confirmed, clear per-frame error state
    logic   rxShift;   // take a data bit
    logic   rxParity;  // compare the parity bit
    logic   rxStop;    // check a stop bit
    logic   rxDone;    // last stop bit sampled, publish the byte
  } strobe_t;

endpackage

// File: rtl/dualpol_uart_ctrl.sv
module dualpol_uart_ctrl
  import dualpol_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    baudTick,
  input  logic    cfgParityEn,
  input  logic    cfgTwoStop,
  input  logic    txValid,
  output logic    txReady,
  input  logic    rxLine,
  input  logic    rxFell,
  output strobe_t strb
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  phase_e           txPh, rxPh;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [BIT_W-1:0] txBit, rxBit;
  logic             txAccept, txEnd, txLastStop;
  logic             rxMid, rxSample, rxLastStop;

  assign txReady    = (txPh == PH_IDLE);
  assign txAccept   = txValid && txReady;
  assign txEnd      = baudTick && (txCnt == CNT_LAST) && (txPh != PH_IDLE);
  assign txLastStop = (txPh == PH_STOP) && !(cfgTwoStop && (txBit == '0));

  // Transmit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPh  <= PH_IDLE;
      txCnt <= '0;
      txBit <= '0;
    end else if (txAccept) begin
      txPh  <= PH_START;
      txCnt <= '0;
      txBit <= '0;
    end else if ((txPh != PH_IDLE) && baudTick) begin
      if (txCnt != CNT_LAST) begin
        txCnt <= txCnt + 1'b1;
      end else begin
        txCnt <= '0;
        case (txPh)
          PH_START: begin
            txPh  <= PH_DATA;
            txBit <= '0;
          end
          PH_DATA: begin
            if (txBit == BIT_LAST) begin
              txPh  <= cfgParityEn ? PH_PARITY : PH_STOP;
              txBit <= '0;
            end else begin
              txBit <= txBit + 1'b1;
            end
          end
          PH_PARITY: begin
            txPh  <= PH_STOP;
            txBit <= '0;
          end
          PH_STOP: begin
            if (txLastStop) txPh <= PH_IDLE;
            else            txBit <= txBit + 1'b1;
          end
          default: txPh <= PH_IDLE;
        endcase
      end
    end
  end

  assign rxMid      = baudTick && (rxPh == PH_START) && (rxCnt == CNT_MID);
  assign rxSample   = baudTick && (rxPh inside {PH_DATA, PH_PARITY, PH_STOP})
                      && (rxCnt == CNT_LAST);
  assign rxLastStop = (rxPh == PH_STOP) && !(cfgTwoStop && (rxBit == '0));

  // Receive sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPh  <= PH_IDLE;
      rxCnt <= '0;
      rxBit <= '0;
    end else begin
      case (rxPh)
        PH_IDLE: begin
          if (rxFell) begin
            rxPh  <= PH_START;
            rxCnt <= '0;
          end
        end
        PH_START: begin
          if (baudTick) begin
            if (rxCnt == CNT_MID) begin
              rxCnt <= '0;
              rxBit <= '0;
              rxPh  <= rxLine ? PH_IDLE : PH_DATA;
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        default: begin
          if (baudTick) begin
            if (rxCnt != CNT_LAST) begin
              rxCnt <= rxCnt + 1'b1;
            end else begin
              rxCnt <= '0;
              case (rxPh)
                PH_DATA: begin
                  if (rxBit == BIT_LAST) begin
                    rxPh  <= cfgParityEn ? PH_PARITY : PH_STOP;
                    rxBit <= '0;
                  end else begin
                    rxBit <= rxBit + 1'b1;
                  end
                end
                PH_PARITY: begin
                  rxPh  <= PH_STOP;
                  rxBit <= '0;
                end
                PH_STOP: begin
                  if (rxLastStop) rxPh <= PH_IDLE;
                  else            rxBit <= rxBit + 1'b1;
                end
                default: rxPh <= PH_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.txLoad   = txAccept;
    strb.txShift  = txEnd && (txPh == PH_DATA);
    strb.txPhase  = txPh;
    strb.rxClear  = rxMid && !rxLine;
    strb.rxShift  = rxSample && (rxPh == PH_DATA);
    strb.rxParity = rxSample && (rxPh == PH_PARITY);
    strb.rxStop   = rxSample && (rxPh == PH_STOP);
    strb.rxDone   = rxSample && rxLastStop;
  end

endmodule

// File: rtl/dualpol_uart_dp.sv
module dualpol_uart_dp
  import dualpol_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              cfgMsbFirst,
  input  logic              cfgParityOdd,
  input  logic              cfgDataInv,
  input  logic              cfgLineInv,
  input  logic [DATA_W-1:0] txData,
  output logic              txd,
  input  logic              rxd,
  input  logic              rxRead,
  output logic              rxLine,
  output logic              rxFell,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParityErr,
  output logic              rxFrameErr,
  output logic              rxOverrun
);

  logic [DATA_W-1:0]      dataMask;
  logic [DATA_W-1:0]      txWord, txSr, rxSr;
  logic                   txPar, txRaw;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrev, parBad, stopBad;

  assign dataMask = {DATA_W{cfgDataInv}};
  assign txWord   = txData ^ dataMask;

  // Transmit shifter; parity covers the bits as they go on the line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSr  <= '0;
      txPar <= 1'b0;
    end else if (strb.txLoad) begin
      txSr  <= txWord;
      txPar <= (^txWord) ^ cfgParityOdd;
    end else if (strb.txShift) begin
      txSr  <= cfgMsbFirst ? {txSr[DATA_W-2:0], 1'b0} : {1'b0, txSr[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strb.txPhase)
      PH_START:  txRaw = 1'b0;
      PH_DATA:   txRaw = cfgMsbFirst ? txSr[DATA_W-1] : txSr[0];
      PH_PARITY: txRaw = txPar;
      default:   txRaw = 1'b1;
    endcase
  end

  assign txd = txRaw ^ cfgLineInv;

  // Input correction ahead of the synchroniser, so a polarity switch
  // and the matching pin change cannot produce a false edge
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxd ^ cfgLineInv;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxd ^ cfgLineInv};
      end
    end
  endgenerate

  assign rxLine = syncQ[SYNC_STAGES-1];
  assign rxFell = rxPrev && !rxLine;

  always_ff @(posedge clk) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxLine;
  end

  // Receive shifter and per-frame error state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSr    <= '0;
      parBad  <= 1'b0;
      stopBad <= 1'b0;
    end else begin
      if (strb.rxShift)
        rxSr <= cfgMsbFirst ? {rxSr[DATA_W-2:0], rxLine} : {rxLine, rxSr[DATA_W-1:1]};
      if (strb.rxClear) begin
        parBad  <= 1'b0;
        stopBad <= 1'b0;
      end else begin
        if (strb.rxParity) parBad  <= rxLine ^ (^rxSr) ^ cfgParityOdd;
        if (strb.rxStop && !rxLine) stopBad <= 1'b1;
      end
    end
  end

  // Read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxOverrun   <= 1'b0;
    end else if (strb.rxDone) begin
      rxData      <= rxSr ^ dataMask;
      rxValid     <= 1'b1;
      rxParityErr <= parBad;
      rxFrameErr  <= stopBad || !rxLine;
      rxOverrun   <= rxValid && !rxRead;
    end else if (rxRead && rxValid) begin
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxOverrun   <= 1'b0;
    end
  end

endmodule

// File: rtl/dualpol_uart.sv
module dualpol_uart
  import dualpol_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              cfgMsbFirst,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              cfgDataInv,
  input  logic              cfgLineInv,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxRead,
  output logic              rxParityErr,
  output logic              rxFrameErr,
  output logic              rxOverrun
);

  strobe_t strb;
  logic    rxLine, rxFell;

  dualpol_uart_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .cfgParityEn(cfgParityEn),
    .cfgTwoStop (cfgTwoStop),
    .txValid    (txValid),
    .txReady    (txReady),
    .rxLine     (rxLine),
    .rxFell     (rxFell),
    .strb       (strb)
  );

  dualpol_uart_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgMsbFirst (cfgMsbFirst),
    .cfgParityOdd(cfgParityOdd),
    .cfgDataInv  (cfgDataInv),
    .cfgLineInv  (cfgLineInv),
    .txData      (txData),
    .txd         (txd),
    .rxd         (rxd),
    .rxRead      (rxRead),
    .rxLine      (rxLine),
    .rxFell      (rxFell),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr),
    .rxOverrun   (rxOverrun)
  );

endmodule

// File: rtl/dualpol_uart_chk.sv
module dualpol_uart_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic cfgLineInv,
  input logic txValid,
  input logic txReady,
  input logic txd,
  input logic rxRead,
  input logic rxValid,
  input logic rxParityErr,
  input logic rxFrameErr,
  input logic rxOverrun
);

  // Idle output sits at the selected polarity
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (txd == !cfgLineInv));

  // A taken byte makes the transmitter busy
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // Output moves only on a baud tick or a handshake, barring a polarity switch
  assert_tick_paced_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!baudTick && !(txValid && txReady)) |=>
      ((txd == $past(txd)) || (cfgLineInv != $past(cfgLineInv))));

  // Received byte held until read
  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxRead) |=> rxValid);

  // Flags only accompany a held byte
  assert_flags_with_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxParityErr || rxFrameErr || rxOverrun) |-> rxValid);

  // Overrun only when an earlier byte was pending
  assert_overrun_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxValid));

endmodule

bind dualpol_uart dualpol_uart_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .baudTick   (baudTick),
  .cfgLineInv (cfgLineInv),
  .txValid    (txValid),
  .txReady    (txReady),
  .txd        (txd),
  .rxRead     (rxRead),
  .rxValid    (rxValid),
  .rxParityErr(rxParityErr),
  .rxFrameErr (rxFrameErr),
  .rxOverrun  (rxOverrun)
);

// File: tb/dualpol_uart_bench.sv
module dualpol_uart_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick;
  logic       cfgMsbFirst = 1'b0, cfgParityEn = 1'b0, cfgParityOdd = 1'b0;
  logic       cfgTwoStop = 1'b0, cfgDataInv = 1'b0, cfgLineInv = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       rxRead = 1'b0;
  logic       useLoop = 1'b1;
  logic       benchRxd = 1'b1;
  logic       rxd;
  logic       txReady, txd, rxValid, rxParityErr, rxFrameErr, rxOverrun;
  logic [7:0] rxData;

  int nChecks = 0;
  int nFails  = 0;

  assign rxd = useLoop ? txd : benchRxd;

  always #5 clk = ~clk;

  always @(posedge clk) baudTick <= rstN ? ~baudTick : 1'b0;

  dualpol_uart u_dualpol_uart (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .cfgMsbFirst(cfgMsbFirst), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop(cfgTwoStop), .cfgDataInv(cfgDataInv), .cfgLineInv(cfgLineInv),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txd(txd), .rxd(rxd),
    .rxData(rxData), .rxValid(rxValid), .rxRead(rxRead),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  function automatic int frameLen();
    return 10 + int'(cfgParityEn) + int'(cfgTwoStop);
  endfunction

  // Frame levels in time order before line inversion
  function automatic logic [11:0] frameBits(input logic [7:0] b);
    logic [11:0] f;
    logic [7:0]  v;
    f    = '1;
    v    = b ^ {8{cfgDataInv}};
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = cfgMsbFirst ? v[7-i] : v[i];
    if (cfgParityEn) f[9] = (^v) ^ cfgParityOdd;
    return f;
  endfunction

  task automatic waitTicks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (baudTick) k++;
    end
  endtask

  task automatic setCfg(input logic [5:0] c);
    @(negedge clk);
    {cfgLineInv, cfgDataInv, cfgTwoStop, cfgParityOdd, cfgParityEn, cfgMsbFirst} = c;
    benchRxd = ~c[5];
    waitTicks(4);
  endtask

  // Send one byte and compare the waveform on txd at mid-bit
  task automatic txCheckFrame(input logic [7:0] b);
    logic [11:0] obs, exp, mask;
    int n;
    n    = frameLen();
    exp  = frameBits(b) ^ {12{cfgLineInv}};
    mask = 12'((1 << n) - 1);
    obs  = '0;
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData  = b;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    check(!txReady, "R7", "busy after accept", 32'(txReady), 32'h0);
    waitTicks(8);
    obs[0] = txd;
    for (int i = 1; i < n; i++) begin
      waitTicks(16);
      obs[i] = txd;
    end
    check(((obs ^ exp) & mask) == 12'h0, "R1/R2/R3/R4/R5", "txd frame",
          32'(obs & mask), 32'(exp & mask));
    while (!txReady) @(negedge clk);
    check(txd == ~cfgLineInv, "R5", "idle level after frame", 32'(txd), 32'(~cfgLineInv));
  endtask

  // Drive a frame straight into rxd
  task automatic driveFrame(input logic [11:0] raw, input int n);
    useLoop = 1'b0;
    for (int i = 0; i < n; i++) begin
      benchRxd = raw[i] ^ cfgLineInv;
      waitTicks(16);
    end
    benchRxd = ~cfgLineInv;
    waitTicks(8);
  endtask

  task automatic expectRx(input logic [7:0] b, input logic par, input logic frm,
                          input logic ovr, input string req, input bit doRead);
    int w = 0;
    while (!rxValid && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check(rxValid == 1'b1, req, "rxValid", 32'(rxValid), 32'h1);
    check(rxData == b, req, "rxData", 32'(rxData), 32'(b));
    check({rxParityErr, rxFrameErr, rxOverrun} == {par, frm, ovr}, req,
          "flags par/frm/ovr", 32'({rxParityErr, rxFrameErr, rxOverrun}),
          32'({par, frm, ovr}));
    if (doRead) begin
      @(negedge clk);
      rxRead = 1'b1;
      @(negedge clk);
      rxRead = 1'b0;
      check({rxValid, rxParityErr, rxFrameErr, rxOverrun} == 4'h0, "R9",
            "cleared by read", 32'({rxValid, rxParityErr, rxFrameErr, rxOverrun}), 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [11:0] f;
    logic [7:0]  b;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    // Reset state
    check(txReady == 1'b1, "R7", "reset txReady", 32'(txReady), 32'h1);
    check(txd == 1'b1, "R1", "reset idle high", 32'(txd), 32'h1);
    check({rxValid, rxParityErr, rxFrameErr, rxOverrun} == 4'h0, "R9", "reset rx",
          32'({rxValid, rxParityErr, rxFrameErr, rxOverrun}), 32'h0);
    rstN = 1'b1;
    waitTicks(4);

    // Loop-back under all four inversion pairs, even parity, one stop
    for (int c = 0; c < 4; c++) begin
      setCfg({c[1], c[0], 1'b0, 1'b0, 1'b1, 1'b0});
      txCheckFrame(8'hB4);
      expectRx(8'hB4, 1'b0, 1'b0, 1'b0, "R4/R5/R6", 1'b1);
    end

    // MSB first, odd parity, two stops
    setCfg(6'b001111);
    txCheckFrame(8'h01);
    expectRx(8'h01, 1'b0, 1'b0, 1'b0, "R2/R3", 1'b1);

    // No parity, data inversion only
    setCfg(6'b010000);
    txCheckFrame(8'hF0);
    expectRx(8'hF0, 1'b0, 1'b0, 1'b0, "R1/R4", 1'b1);

    // Receiver fed an inverted line directly, data also inverted
    setCfg(6'b110110);
    f = frameBits(8'h3C);
    driveFrame(f, frameLen());
    expectRx(8'h3C, 1'b0, 1'b0, 1'b0, "R6/R4", 1'b1);

    // Corrupted parity bit
    setCfg(6'b000010);
    f = frameBits(8'h5A);
    f[9] = ~f[9];
    driveFrame(f, frameLen());
    expectRx(8'h5A, 1'b1, 1'b0, 1'b0, "R10", 1'b1);

    // Second stop bit low
    setCfg(6'b001010);
    f = frameBits(8'hA7);
    f[11] = 1'b0;
    driveFrame(f, frameLen());
    expectRx(8'hA7, 1'b0, 1'b1, 1'b0, "R11", 1'b1);

    // Only stop bit low, no parity
    setCfg(6'b000001);
    f = frameBits(8'h6D);
    f[9] = 1'b0;
    driveFrame(f, frameLen());
    expectRx(8'h6D, 1'b0, 1'b1, 1'b0, "R11", 1'b1);

    // Short false start on an inverted line
    setCfg(6'b100000);
    useLoop  = 1'b0;
    benchRxd = cfgLineInv;
    waitTicks(3);
    benchRxd = ~cfgLineInv;
    waitTicks(40);
    check(rxValid == 1'b0, "R8", "false start ignored", 32'(rxValid), 32'h0);
    f = frameBits(8'hC3);
    driveFrame(f, frameLen());
    expectRx(8'hC3, 1'b0, 1'b0, 1'b0, "R8", 1'b1);

    // Two frames without a read
    setCfg(6'b000000);
    useLoop = 1'b1;
    txCheckFrame(8'h11);
    expectRx(8'h11, 1'b0, 1'b0, 1'b0, "R9", 1'b0);
    waitTicks(20);
    check(rxValid == 1'b1, "R9", "held while unread", 32'(rxValid), 32'h1);
    txCheckFrame(8'h22);
    expectRx(8'h22, 1'b0, 1'b0, 1'b1, "R12", 1'b1);

    // Random bytes and configurations through the loop-back
    for (int i = 0; i < 20; i++) begin
      setCfg(6'($urandom));
      useLoop = 1'b1;
      b = 8'($urandom);
      txCheckFrame(b);
      expectRx(b, 1'b0, 1'b0, 1'b0, "R1/R2/R3/R4/R5/R6", 1'b1);
    end

    summary();
  end

endmodule